// File: doc/BRIEF.md
# Multi-Lane Ramp Test Pattern Checker

This block checks an incrementing octet test pattern that arrives on several lanes of a serial converter link while the transport layer is bypassed. On each beat the lanes should all carry the same octet, and that octet should be one more than the octet on the previous valid beat. The count wraps from 0xFF to 0x00. No seed is fixed in advance. The first valid beat after the checker becomes active loads its starting point from lane 0.

The checker is active only while the test-control enable bit and the link-up indicator are both high and no clear is applied. Lane `i` occupies bits `[8i+7:8i]` of the data bus. All outputs are registered. The flags for a beat appear on the clock edge after that beat is presented and stay up for one cycle. A 16-bit saturating counter records how many beats contained an error. A clear pulse zeroes the counter and drops the lock.

Top module: `ramp_chk_top`

## Requirements
- R1: After reset, `locked_o` is 0, `lane_err_o` is all zeros, `xlane_err_o` is 0 and `err_cnt_o` is 0.
- R2: Valid beats are ignored in three cases: `en_i` is low, `link_up_i` is low, or `clr_i` is high. In these cases the checker does not lock, raises no flag and does not count.
- R3: The first valid beat of an active checker sets `locked_o` on the next edge. That beat seeds the expected value with lane 0 plus one. It never raises a `lane_err_o` bit.
- R4: On each later valid beat, bit `i` of `lane_err_o` is 1 on the next edge exactly when lane `i` differs from the expected value. Counting from 0xFF to 0x00 is accepted as correct.
- R5: On every valid beat of an active checker, `xlane_err_o` is 1 on the next edge when any lane differs from lane 0. This includes the seeding beat.
- R6: After every valid beat the expected value becomes the received lane 0 octet plus one, modulo 256. A single wrong octet therefore yields a single error beat.
- R7: A beat with `valid_i` low does not advance the expected value. On the next edge `lane_err_o` is zero and `xlane_err_o` is 0.
- R8: `err_cnt_o` rises by exactly one for each valid beat that raises any lane or cross-lane flag. The increment is visible on the same edge as the flags. The counter saturates at 65535.
- R9: A `clr_i` pulse sets `err_cnt_o` to 0 and `locked_o` to 0 on the next edge. The next valid beat reseeds the checker.
- R10: When `en_i` or `link_up_i` goes low, `locked_o` is 0 on the next edge, and the checker reseeds when it becomes active again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Ramp check enable from the test-control register |
| link_up_i | input | 1 | Link is up |
| clr_i | input | 1 | Clears the counter and drops the lock |
| valid_i | input | 1 | Data beat is valid |
| data_i | input | 8*NUM_LANES | Octet per lane; lane i at bits [8i+7:8i] |
| lane_err_o | output | NUM_LANES | Per-lane ramp mismatch for the last beat |
| xlane_err_o | output | 1 | Lanes differed on the last beat |
| locked_o | output | 1 | Checker has seeded and is tracking |
| err_cnt_o | output | 16 | Saturating count of error beats |

## Verification
Saturation of the error counter is the hardest case to reach from the ports, because it needs 65535 error beats. The bench clears the counter and then drives a long run of back-to-back valid beats in which one lane always differs from lane 0. Every beat then counts, and the run continues past the limit to confirm the counter stays at 65535. A second hard case is telling the behaviour after resynchronisation apart from a checker that keeps a stale expected value. The bench covers it by injecting one wrong octet on all lanes and then continuing the ramp from the wrong value.

// File: rtl/ramp_chk_pkg.sv
package ramp_chk_pkg;
  localparam int OCT_W = 8;
  typedef logic [OCT_W-1:0] octet_t;

  function automatic octet_t ramp_next(input octet_t v);
    return v + octet_t'(1);
  endfunction
endpackage

// File: rtl/ramp_lane_cmp.sv
module ramp_lane_cmp
  import ramp_chk_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic [NUM_LANES*OCT_W-1:0] data_i,
  input  octet_t                     expect_i,
  output logic [NUM_LANES-1:0]       ramp_miss_o,
  output logic [NUM_LANES-1:0]       ref_diff_o
);
  octet_t ref_oct;
  assign ref_oct = data_i[OCT_W-1:0];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    octet_t oct;
    assign oct            = data_i[g*OCT_W +: OCT_W];
    assign ramp_miss_o[g] = (oct != expect_i);
    assign ref_diff_o[g]  = (oct != ref_oct);
  end
endmodule

// File: rtl/ramp_tracker.sv
module ramp_tracker
  import ramp_chk_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   active_i,
  input  logic   valid_i,
  input  octet_t seed_i,
  output octet_t expect_o,
  output logic   locked_o
);
  always_ff @(posedge clk) begin
    if (rst || !active_i) begin
      locked_o <= 1'b0;
      expect_o <= '0;
    end else if (valid_i) begin
      locked_o <= 1'b1;
      expect_o <= ramp_next(seed_i);
    end
  end
endmodule

// File: rtl/ramp_err_counter.sv
module ramp_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_MAX)
      cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ramp_chk_top.sv
module ramp_chk_top
  import ramp_chk_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en_i,
  input  logic                       link_up_i,
  input  logic                       clr_i,
  input  logic                       valid_i,
  input  logic [NUM_LANES*OCT_W-1:0] data_i,
  output logic [NUM_LANES-1:0]       lane_err_o,
  output logic                       xlane_err_o,
  output logic                       locked_o,
  output logic [CNT_W-1:0]           err_cnt_o
);
  logic                 active;
  logic                 beat;
  octet_t               expect_q;
  logic                 locked_q;
  logic [NUM_LANES-1:0] ramp_miss;
  logic [NUM_LANES-1:0] ref_diff;
  logic [NUM_LANES-1:0] lane_err_d;
  logic                 xlane_d;

  assign active = en_i && link_up_i && !clr_i;
  assign beat   = active && valid_i;

  ramp_lane_cmp #(.NUM_LANES(NUM_LANES)) u_cmp (
    .data_i      (data_i),
    .expect_i    (expect_q),
    .ramp_miss_o (ramp_miss),
    .ref_diff_o  (ref_diff)
  );

  ramp_tracker u_trk (
    .clk      (clk),
    .rst      (rst),
    .active_i (active),
    .valid_i  (valid_i),
    .seed_i   (data_i[OCT_W-1:0]),
    .expect_o (expect_q),
    .locked_o (locked_q)
  );

  assign lane_err_d = (beat && locked_q) ? ramp_miss : '0;
  assign xlane_d    = beat && (|ref_diff);

  ramp_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr_i (clr_i),
    .inc_i ((|lane_err_d) || xlane_d),
    .cnt_o (err_cnt_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_err_o  <= '0;
      xlane_err_o <= 1'b0;
    end else begin
      lane_err_o  <= lane_err_d;
      xlane_err_o <= xlane_d;
    end
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/ramp_chk_sva.sv
module ramp_chk_sva #(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en_i,
  input logic                 link_up_i,
  input logic                 clr_i,
  input logic                 valid_i,
  input logic [NUM_LANES-1:0] lane_err_o,
  input logic                 xlane_err_o,
  input logic                 locked_o,
  input logic [CNT_W-1:0]     err_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2
  inactive_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_i || !link_up_i || clr_i) |=> (lane_err_o == '0 && !xlane_err_o));

  // R3
  seed_no_lane_err_chk: assert property (@(posedge clk) disable iff (rst)
    !locked_o |=> (lane_err_o == '0));

  // R7
  idle_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (lane_err_o == '0 && !xlane_err_o));

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (err_cnt_o == $past(err_cnt_o) || err_cnt_o == $past(err_cnt_o) + 1'b1));

  // R8
  cnt_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && err_cnt_o != CNT_MAX) |=>
      (((lane_err_o != '0) || xlane_err_o) == (err_cnt_o != $past(err_cnt_o))));

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (err_cnt_o == CNT_MAX && !clr_i) |=> (err_cnt_o == CNT_MAX));

  // R9
  clr_effect_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (err_cnt_o == '0 && !locked_o));

  // R10
  link_drop_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_i || !link_up_i) |=> !locked_o);
endmodule

bind ramp_chk_top ramp_chk_sva #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .en_i        (en_i),
  .link_up_i   (link_up_i),
  .clr_i       (clr_i),
  .valid_i     (valid_i),
  .lane_err_o  (lane_err_o),
  .xlane_err_o (xlane_err_o),
  .locked_o    (locked_o),
  .err_cnt_o   (err_cnt_o)
);

// File: tb/ramp_chk_top_tb.sv
module ramp_chk_top_tb;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en_i = 1'b0;
  logic          link_up_i = 1'b0;
  logic          clr_i = 1'b0;
  logic          valid_i = 1'b0;
  logic [NL*8-1:0] data_i = '0;
  logic [NL-1:0] lane_err_o;
  logic          xlane_err_o;
  logic          locked_o;
  logic [15:0]   err_cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ramp_chk_top u_dut (
    .clk(clk), .rst(rst), .en_i(en_i), .link_up_i(link_up_i), .clr_i(clr_i),
    .valid_i(valid_i), .data_i(data_i), .lane_err_o(lane_err_o),
    .xlane_err_o(xlane_err_o), .locked_o(locked_o), .err_cnt_o(err_cnt_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int le, input bit xe, input bit lk, input int cnt);
    check(lane_err_o == le[NL-1:0], {req, " lane_err"}, int'(lane_err_o), le);
    check(xlane_err_o == xe, {req, " xlane"}, int'(xlane_err_o), int'(xe));
    check(locked_o == lk, {req, " locked"}, int'(locked_o), int'(lk));
    check(err_cnt_o == cnt[15:0], {req, " count"}, int'(err_cnt_o), cnt);
  endtask

  function automatic logic [NL*8-1:0] all_lanes(input logic [7:0] v);
    return {NL{v}};
  endfunction

  // present one beat on the falling edge, sample 1 ns after the capturing edge
  task automatic beat(input bit v, input logic [NL*8-1:0] d);
    @(negedge clk);
    valid_i = v;
    data_i  = d;
    @(posedge clk);
    #1;
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk_out("R1", 0, 0, 0, 0);
  endtask

  task automatic t_gate;
    en_i = 1'b0; link_up_i = 1'b1;
    beat(1'b1, 32'h11223344);
    chk_out("R2 en low", 0, 0, 0, 0);
    en_i = 1'b1; link_up_i = 1'b0;
    beat(1'b1, 32'h11223344);
    chk_out("R2 link low", 0, 0, 0, 0);
    link_up_i = 1'b1;
    @(negedge clk); clr_i = 1'b1; valid_i = 1'b1; data_i = 32'h01020304;
    @(posedge clk); #1; clr_i = 1'b0; valid_i = 1'b0;
    chk_out("R2 clr high", 0, 0, 0, 0);
  endtask

  task automatic t_ramp_wrap;
    beat(1'b1, all_lanes(8'hFD));
    chk_out("R3 seed", 0, 0, 1, 0);
    beat(1'b1, all_lanes(8'hFE)); chk_out("R4 step", 0, 0, 1, 0);
    beat(1'b1, all_lanes(8'hFF)); chk_out("R4 to FF", 0, 0, 1, 0);
    beat(1'b1, all_lanes(8'h00)); chk_out("R4 wrap", 0, 0, 1, 0);
    beat(1'b1, all_lanes(8'h01)); chk_out("R4 after wrap", 0, 0, 1, 0);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 3; i++) begin
      beat(1'b0, 32'hDEADBEEF);
      chk_out("R7 idle", 0, 0, 1, 0);
    end
    beat(1'b1, all_lanes(8'h02));
    chk_out("R7 no advance", 0, 0, 1, 0);
  endtask

  task automatic t_lane_fault;
    logic [NL*8-1:0] d;
    d = all_lanes(8'h03);
    d[2*8 +: 8] = 8'h77;
    beat(1'b1, d);
    chk_out("R4 R5 lane2 fault", 4'b0100, 1, 1, 1);
    beat(1'b1, all_lanes(8'h04));
    chk_out("R6 after lane fault", 0, 0, 1, 1);
  endtask

  task automatic t_resync;
    beat(1'b1, all_lanes(8'h50));
    chk_out("R6 bad octet", 4'hF, 0, 1, 2);
    beat(1'b1, all_lanes(8'h51));
    chk_out("R6 resynced", 0, 0, 1, 2);
    beat(1'b1, all_lanes(8'h52));
    chk_out("R6 continues", 0, 0, 1, 2);
  endtask

  task automatic t_clear;
    logic [NL*8-1:0] d;
    @(negedge clk); clr_i = 1'b1;
    @(posedge clk); #1; clr_i = 1'b0;
    chk_out("R9 clear", 0, 0, 0, 0);
    d = all_lanes(8'h90);
    d[3*8 +: 8] = 8'h91;
    beat(1'b1, d);
    chk_out("R5 R9 reseed xlane", 0, 1, 1, 1);
    beat(1'b1, all_lanes(8'h91));
    chk_out("R9 reseeded", 0, 0, 1, 1);
  endtask

  task automatic t_link_drop;
    @(negedge clk); link_up_i = 1'b0;
    @(posedge clk); #1;
    chk_out("R10 link drop", 0, 0, 0, 1);
    link_up_i = 1'b1;
    beat(1'b1, all_lanes(8'h20));
    chk_out("R10 reseed", 0, 0, 1, 1);
    beat(1'b1, all_lanes(8'h21));
    chk_out("R10 tracking", 0, 0, 1, 1);
    @(negedge clk); en_i = 1'b0;
    @(posedge clk); #1;
    chk_out("R10 enable drop", 0, 0, 0, 1);
    en_i = 1'b1;
  endtask

  task automatic t_saturate;
    logic [NL*8-1:0] d;
    @(negedge clk); clr_i = 1'b1;
    @(posedge clk); #1; clr_i = 1'b0;
    d = all_lanes(8'h00);
    d[1*8 +: 8] = 8'hAA;
    @(negedge clk); valid_i = 1'b1;
    for (int i = 0; i < 65534; i++) begin
      data_i = d;
      d[7:0] = d[7:0] + 8'd1;
      @(negedge clk);
    end
    valid_i = 1'b0;
    check(err_cnt_o == 16'hFFFE, "R8 count 65534", int'(err_cnt_o), 32'hFFFE);
    beat(1'b1, d);
    check(err_cnt_o == 16'hFFFF, "R8 reach max", int'(err_cnt_o), 32'hFFFF);
    for (int i = 0; i < 4; i++) beat(1'b1, d);
    check(err_cnt_o == 16'hFFFF, "R8 saturated", int'(err_cnt_o), 32'hFFFF);
    check(xlane_err_o == 1'b1, "R8 flag at max", int'(xlane_err_o), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset;
    t_gate;
    t_ramp_wrap;
    t_idle;
    t_lane_fault;
    t_resync;
    t_clear;
    t_link_drop;
    t_saturate;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    end
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule